// File: doc/BRIEF.md
# Effective Address and Operand Fetch Unit

This unit sits between instruction decode and execution. Once both words of an instruction have been fetched, decode presents a 4-bit mode code, the instruction's address field, a register selector and a start pulse. The unit forms the effective address for that mode and, where the mode names a memory location, reads the operand through a single-port memory read interface. That interface has a fixed one-cycle latency. The memory-indirect mode makes two reads: the first fetches a pointer and the second fetches the operand. When the result is ready, the unit raises a one-cycle done strobe. The effective address and the operand then hold until the next accepted start.

The unit contains an eight-entry register file. Decode preloads it through a write port. The register modes read it, and the post-increment and pre-decrement modes update it. The program counter, index register and base register come in as plain inputs. The program counter must already point past both instruction words. Address arithmetic wraps modulo 2^ADDR_W. Codes 11 to 15 are undefined and finish at once with an error flag.

Top module: `ea_unit`

## Requirements
- R1: After reset, done, busy, mem_re and mode_err are 0, ea and operand are 0, and every register file entry is 0.
- R2: Mode 0 (implied) finishes with done one cycle after start, with no memory read, ea = 0 and operand = 0.
- R3: Mode 1 (immediate) finishes one cycle after start, with no read, operand = address field zero-extended and ea = 0.
- R4: Mode 4 (register) finishes one cycle after start, with no read, operand = selected register and ea = 0.
- R5: Mode 2 (direct) performs exactly one read at the address field, giving ea = field and operand = memory word. Done follows three cycles after start.
- R6: Mode 3 (indirect) reads the word at the field and takes its low ADDR_W bits as ea. It then reads the operand at ea. That makes exactly two reads, and done follows five cycles after start.
- R7: Mode 5 (register indirect) uses the low ADDR_W bits of the selected register as ea and makes one read. The register is left unchanged.
- R8: Mode 6 (post-increment) uses the register's old value as ea and makes one read. Afterwards the register holds old+1 modulo 2^DATA_W.
- R9: Mode 7 (pre-decrement) first decrements the register modulo 2^DATA_W, then uses the new value as ea and makes one read.
- R10: Modes 8, 9 and 10 (relative, indexed, base) each make one read. Their ea is pc, xr or bar respectively plus field, modulo 2^ADDR_W.
- R11: Codes 11 to 15 finish one cycle after start with mode_err = 1, ea = 0, operand = 0 and no read. Any accepted start with a defined code leaves mode_err at 0.
- R12: A start while busy is ignored. A register write request is ignored while busy or while start is high.
- R13: mem_re is a one-cycle pulse per read. Read data is taken the cycle after the request. done is never high while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin address calculation (taken only when idle) |
| mode | input | 4 | Addressing mode code |
| field | input | ADDR_W | Instruction address field |
| reg_sel | input | SEL_W | Register file entry for register-based modes |
| pc | input | ADDR_W | Program counter after both instruction words |
| xr | input | ADDR_W | Index register |
| bar | input | ADDR_W | Base register |
| rf_we | input | 1 | Register file write request |
| rf_waddr | input | SEL_W | Register file write index |
| rf_wdata | input | DATA_W | Register file write data |
| mem_re | output | 1 | Memory read request |
| mem_addr | output | ADDR_W | Memory read address |
| mem_rdata | input | DATA_W | Memory read data, valid one cycle after the request |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion strobe |
| ea | output | ADDR_W | Effective address |
| operand | output | DATA_W | Fetched operand |
| mode_err | output | 1 | Last accepted mode code was undefined |

## Verification
The stimulus mixes random mode codes across all sixteen values with random fields, pc, xr and bar values and register contents. The random fields make the additions wrap at the top of the address space, which separates modulo arithmetic from a widened sum. Directed runs cover several things:
- Repeated post-increment and pre-decrement runs on one register, read back through register mode. These tell old-value from new-value addressing and show whether the update is applied exactly once.
- An indirect pointer whose upper bits are set. This shows whether the pointer is truncated to ADDR_W bits.
- A start pulse and a register write issued mid-operation. These show whether the unit wrongly accepts them while busy.
- The latency and the count of read pulses for every mode. Together these separate one-read, two-read and no-read paths.

// File: rtl/ea_pkg.sv
// Package: shared mode codes and controller states for the effective
// address unit. Assumes a 4-bit mode code with 11 defined values.
package ea_pkg;

    typedef enum logic [3:0] {
        AM_IMPLIED  = 4'd0,
        AM_IMMED    = 4'd1,
        AM_DIRECT   = 4'd2,
        AM_INDIRECT = 4'd3,
        AM_REG      = 4'd4,
        AM_REG_IND  = 4'd5,
        AM_POST_INC = 4'd6,
        AM_PRE_DEC  = 4'd7,
        AM_PC_REL   = 4'd8,
        AM_INDEXED  = 4'd9,
        AM_BASED    = 4'd10
    } addr_mode_e;

    localparam logic [3:0] AM_LAST_DEFINED = 4'd10;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_REQ_PTR = 3'd1,
        ST_CAP_PTR = 3'd2,
        ST_REQ_OPD = 3'd3,
        ST_CAP_OPD = 3'd4
    } ea_state_e;

endpackage

// File: rtl/ea_regfile.sv
// Module: register file for register-based addressing modes.
// One read port. Two write ports: an update port from the unit itself
// (auto-increment/decrement), which wins over the external load port.
// Assumes the caller gates the external port while an operation runs.
module ea_regfile #(
    parameter int DATA_W = 16,
    parameter int NREG   = 8,
    localparam int SEL_W = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_we,
    input  logic [SEL_W-1:0]  ext_addr,
    input  logic [DATA_W-1:0] ext_wdata,
    input  logic              upd_we,
    input  logic [SEL_W-1:0]  upd_addr,
    input  logic [DATA_W-1:0] upd_wdata,
    input  logic [SEL_W-1:0]  rd_addr,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] regs [NREG];

    for (genvar gi = 0; gi < NREG; gi++) begin : g_entry
        // Hold one entry; self-update has priority over external load.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                regs[gi] <= '0;
            end else if (upd_we && (upd_addr == SEL_W'(gi))) begin
                regs[gi] <= upd_wdata;
            end else if (ext_we && (ext_addr == SEL_W'(gi))) begin
                regs[gi] <= ext_wdata;
            end
        end
    end

    // Combinational read of the selected entry.
    always_comb begin
        rd_data = regs[rd_addr];
    end

endmodule

// File: rtl/ea_addr_calc.sv
// Module: combinational mode decoder and address adder.
// For the presented mode it produces the first memory address (or the
// pointer address for indirect), the operand for modes that need no
// memory, and the register update for post-increment/pre-decrement.
// Assumes ADDR_W <= DATA_W; register and pointer values are truncated to
// ADDR_W bits when used as an address. All sums wrap modulo 2^ADDR_W.
module ea_addr_calc
    import ea_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 16
) (
    input  logic [3:0]        mode,
    input  logic [ADDR_W-1:0] field,
    input  logic [ADDR_W-1:0] pc,
    input  logic [ADDR_W-1:0] xr,
    input  logic [ADDR_W-1:0] bar,
    input  logic [DATA_W-1:0] reg_val,
    output logic              mode_bad,
    output logic              no_mem,
    output logic              two_reads,
    output logic [ADDR_W-1:0] first_addr,
    output logic [DATA_W-1:0] local_operand,
    output logic              reg_upd_en,
    output logic [DATA_W-1:0] reg_upd_val
);

    logic [DATA_W-1:0] reg_inc;
    logic [DATA_W-1:0] reg_dec;
    logic [ADDR_W-1:0] base_sel;
    logic              use_adder;

    // Register plus/minus one, full register width.
    always_comb begin
        reg_inc = reg_val + DATA_W'(1);
        reg_dec = reg_val - DATA_W'(1);
    end

    // Pick the base for the three adder modes.
    always_comb begin
        use_adder = 1'b1;
        base_sel  = '0;
        unique case (mode)
            AM_PC_REL:  base_sel = pc;
            AM_INDEXED: base_sel = xr;
            AM_BASED:   base_sel = bar;
            default:    use_adder = 1'b0;
        endcase
    end

    // Decode mode into path, address, local operand and register update.
    always_comb begin
        mode_bad      = 1'b0;
        no_mem        = 1'b0;
        two_reads     = 1'b0;
        first_addr    = '0;
        local_operand = '0;
        reg_upd_en    = 1'b0;
        reg_upd_val   = reg_val;
        if (use_adder) begin
            first_addr = base_sel + field;
        end else begin
            unique case (mode)
                AM_IMPLIED: no_mem = 1'b1;
                AM_IMMED: begin
                    no_mem        = 1'b1;
                    local_operand = DATA_W'(field);
                end
                AM_REG: begin
                    no_mem        = 1'b1;
                    local_operand = reg_val;
                end
                AM_DIRECT:   first_addr = field;
                AM_INDIRECT: begin
                    two_reads  = 1'b1;
                    first_addr = field;
                end
                AM_REG_IND:  first_addr = reg_val[ADDR_W-1:0];
                AM_POST_INC: begin
                    first_addr  = reg_val[ADDR_W-1:0];
                    reg_upd_en  = 1'b1;
                    reg_upd_val = reg_inc;
                end
                AM_PRE_DEC: begin
                    first_addr  = reg_dec[ADDR_W-1:0];
                    reg_upd_en  = 1'b1;
                    reg_upd_val = reg_dec;
                end
                default: begin
                    mode_bad = 1'b1;
                    no_mem   = 1'b1;
                end
            endcase
        end
    end

endmodule

// File: rtl/ea_ctrl.sv
// Module: sequencing FSM. Accepts a start only when idle, issues
// one-cycle read pulses, captures read data one cycle after each pulse,
// and raises a one-cycle done. Assumes memory data is valid in the
// cycle after the cycle in which mem_re is high.
module ea_ctrl
    import ea_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              mode_bad,
    input  logic              no_mem,
    input  logic              two_reads,
    input  logic [ADDR_W-1:0] first_addr,
    input  logic [DATA_W-1:0] local_operand,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              accept,
    output logic              mem_re,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              busy,
    output logic              done,
    output logic [ADDR_W-1:0] ea,
    output logic [DATA_W-1:0] operand,
    output logic              mode_err
);

    ea_state_e state;

    // A start is taken only in the idle state.
    always_comb begin
        accept = start && (state == ST_IDLE);
        busy   = (state != ST_IDLE);
    end

    // State, read requests and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            mem_re   <= 1'b0;
            mem_addr <= '0;
            done     <= 1'b0;
            ea       <= '0;
            operand  <= '0;
            mode_err <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (accept) begin
                        mode_err <= mode_bad;
                        if (no_mem) begin
                            ea      <= '0;
                            operand <= local_operand;
                            done    <= 1'b1;
                        end else begin
                            mem_re   <= 1'b1;
                            mem_addr <= first_addr;
                            ea       <= first_addr;
                            state    <= two_reads ? ST_REQ_PTR : ST_REQ_OPD;
                        end
                    end
                end
                ST_REQ_PTR: begin
                    mem_re <= 1'b0;
                    state  <= ST_CAP_PTR;
                end
                ST_CAP_PTR: begin
                    ea       <= mem_rdata[ADDR_W-1:0];
                    mem_addr <= mem_rdata[ADDR_W-1:0];
                    mem_re   <= 1'b1;
                    state    <= ST_REQ_OPD;
                end
                ST_REQ_OPD: begin
                    mem_re <= 1'b0;
                    state  <= ST_CAP_OPD;
                end
                ST_CAP_OPD: begin
                    operand <= mem_rdata;
                    done    <= 1'b1;
                    state   <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/ea_unit.sv
// Module: top of the effective address and operand fetch unit.
// Ties the register file, the mode decoder/adder and the sequencer.
// Assumes ADDR_W <= DATA_W and that pc already points past the whole
// instruction. Register writes from outside are taken only when idle
// and no start is presented.
module ea_unit #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 16,
    parameter int NREG   = 8,
    localparam int SEL_W = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [3:0]        mode,
    input  logic [ADDR_W-1:0] field,
    input  logic [SEL_W-1:0]  reg_sel,
    input  logic [ADDR_W-1:0] pc,
    input  logic [ADDR_W-1:0] xr,
    input  logic [ADDR_W-1:0] bar,
    input  logic              rf_we,
    input  logic [SEL_W-1:0]  rf_waddr,
    input  logic [DATA_W-1:0] rf_wdata,
    output logic              mem_re,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              busy,
    output logic              done,
    output logic [ADDR_W-1:0] ea,
    output logic [DATA_W-1:0] operand,
    output logic              mode_err
);

    logic              accept;
    logic              mode_bad;
    logic              no_mem;
    logic              two_reads;
    logic [ADDR_W-1:0] first_addr;
    logic [DATA_W-1:0] local_operand;
    logic              reg_upd_en;
    logic [DATA_W-1:0] reg_upd_val;
    logic [DATA_W-1:0] reg_val;
    logic              ext_we;
    logic              upd_we;

    // Gate register writes: external only when quiet, update only on accept.
    always_comb begin
        ext_we = rf_we && !busy && !start;
        upd_we = accept && reg_upd_en;
    end

    ea_regfile #(
        .DATA_W (DATA_W),
        .NREG   (NREG)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .ext_we    (ext_we),
        .ext_addr  (rf_waddr),
        .ext_wdata (rf_wdata),
        .upd_we    (upd_we),
        .upd_addr  (reg_sel),
        .upd_wdata (reg_upd_val),
        .rd_addr   (reg_sel),
        .rd_data   (reg_val)
    );

    ea_addr_calc #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_calc (
        .mode          (mode),
        .field         (field),
        .pc            (pc),
        .xr            (xr),
        .bar           (bar),
        .reg_val       (reg_val),
        .mode_bad      (mode_bad),
        .no_mem        (no_mem),
        .two_reads     (two_reads),
        .first_addr    (first_addr),
        .local_operand (local_operand),
        .reg_upd_en    (reg_upd_en),
        .reg_upd_val   (reg_upd_val)
    );

    ea_ctrl #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .start         (start),
        .mode_bad      (mode_bad),
        .no_mem        (no_mem),
        .two_reads     (two_reads),
        .first_addr    (first_addr),
        .local_operand (local_operand),
        .mem_rdata     (mem_rdata),
        .accept        (accept),
        .mem_re        (mem_re),
        .mem_addr      (mem_addr),
        .busy          (busy),
        .done          (done),
        .ea            (ea),
        .operand       (operand),
        .mode_err      (mode_err)
    );

endmodule

// File: rtl/ea_unit_chk.sv
// Module: protocol and mode checker for ea_unit, attached by bind.
// Watches only top-level ports.
module ea_unit_chk #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [3:0]        mode,
    input logic [ADDR_W-1:0] field,
    input logic [ADDR_W-1:0] pc,
    input logic              mem_re,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              busy,
    input logic              done,
    input logic [DATA_W-1:0] operand,
    input logic              mode_err
);

    logic take;

    // A start the unit must accept.
    always_comb take = start && !busy;

    // R2: implied mode finishes next cycle without a read.
    p_implied_r2: assert property (@(posedge clk) disable iff (!rst_n)
        take && (mode == 4'd0) |=> done && !mem_re && (operand == '0));

    // R3: immediate mode returns the field as operand next cycle.
    p_immediate_r3: assert property (@(posedge clk) disable iff (!rst_n)
        take && (mode == 4'd1) |=> done && !mem_re && (operand == DATA_W'($past(field))));

    // R5: direct mode requests the field address.
    p_direct_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
        take && (mode == 4'd2) |=> mem_re && (mem_addr == $past(field)));

    // R10: relative mode requests pc plus field, wrapped.
    p_relative_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
        take && (mode == 4'd8) |=> mem_re && (mem_addr == ADDR_W'($past(pc) + $past(field))));

    // R11: undefined codes finish next cycle with the error flag.
    p_bad_mode_r11: assert property (@(posedge clk) disable iff (!rst_n)
        take && (mode > 4'd10) |=> done && mode_err && !mem_re);

    // R13: a read request lasts one cycle.
    p_read_pulse_r13: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re |=> !mem_re);

    // R13: completion is never reported while still busy.
    p_done_idle_r13: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R12: an ignored start does not restart the unit mid-operation.
    p_busy_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !done && !mem_re |=> busy || done);

endmodule

bind ea_unit ea_unit_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .mode     (mode),
    .field    (field),
    .pc       (pc),
    .mem_re   (mem_re),
    .mem_addr (mem_addr),
    .busy     (busy),
    .done     (done),
    .operand  (operand),
    .mode_err (mode_err)
);

// File: tb/ea_unit_test.sv
module ea_unit_test;

    localparam int AW = 12;
    localparam int DW = 16;
    localparam int NR = 8;
    localparam int SW = $clog2(NR);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [3:0]    mode = '0;
    logic [AW-1:0] field = '0;
    logic [SW-1:0] reg_sel = '0;
    logic [AW-1:0] pc = '0;
    logic [AW-1:0] xr = '0;
    logic [AW-1:0] bar = '0;
    logic          rf_we = 1'b0;
    logic [SW-1:0] rf_waddr = '0;
    logic [DW-1:0] rf_wdata = '0;
    logic          mem_re;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_rdata = '0;
    logic          busy;
    logic          done;
    logic [AW-1:0] ea;
    logic [DW-1:0] operand;
    logic          mode_err;

    int checks = 0;
    int failures = 0;
    int rd_cnt = 0;
    logic [DW-1:0] model_regs [NR];

    always #5 clk = ~clk;

    ea_unit #(.ADDR_W(AW), .DATA_W(DW), .NREG(NR)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .field(field),
        .reg_sel(reg_sel), .pc(pc), .xr(xr), .bar(bar), .rf_we(rf_we),
        .rf_waddr(rf_waddr), .rf_wdata(rf_wdata), .mem_re(mem_re),
        .mem_addr(mem_addr), .mem_rdata(mem_rdata), .busy(busy), .done(done),
        .ea(ea), .operand(operand), .mode_err(mode_err)
    );

    // Memory contents are a fixed function of the address.
    function automatic logic [DW-1:0] mem_word(input logic [AW-1:0] a);
        logic [31:0] t;
        t = {20'd0, a} * 32'd40503 + 32'd7919;
        return t[DW-1:0] ^ 16'hA5C3;
    endfunction

    // Memory model: one-cycle read latency, counts read pulses.
    always @(posedge clk) begin
        if (mem_re) begin
            mem_rdata <= mem_word(mem_addr);
            rd_cnt <= rd_cnt + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic string req_of(input logic [3:0] m);
        case (m)
            4'd0: return "R2";   4'd1: return "R3";   4'd4: return "R4";
            4'd2: return "R5";   4'd3: return "R6";   4'd5: return "R7";
            4'd6: return "R8";   4'd7: return "R9";
            4'd8, 4'd9, 4'd10: return "R10";
            default: return "R11";
        endcase
    endfunction

    task automatic write_reg(input logic [SW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        rf_we = 1'b1; rf_waddr = a; rf_wdata = d;
        @(negedge clk);
        rf_we = 1'b0;
        model_regs[a] = d;
    endtask

    // Run one operation and compare with values computed from the requirements.
    task automatic run_op(input logic [3:0] m, input logic [AW-1:0] f,
                          input logic [SW-1:0] s, input bit disturb);
        logic [AW-1:0] e_ea;
        logic [DW-1:0] e_op;
        logic [DW-1:0] r;
        int e_lat;
        int e_rd;
        int cyc;
        int rd0;
        bit got;
        string q;
        q = req_of(m);
        r = model_regs[s];
        e_ea = '0; e_op = '0; e_lat = 3; e_rd = 1;
        case (m)
            4'd0: begin e_lat = 1; e_rd = 0; end
            4'd1: begin e_lat = 1; e_rd = 0; e_op = DW'(f); end
            4'd4: begin e_lat = 1; e_rd = 0; e_op = r; end
            4'd2: e_ea = f;
            4'd3: begin e_lat = 5; e_rd = 2; e_ea = mem_word(f)[AW-1:0]; end
            4'd5: e_ea = r[AW-1:0];
            4'd6: begin e_ea = r[AW-1:0]; model_regs[s] = r + 1'b1; end
            4'd7: begin model_regs[s] = r - 1'b1; e_ea = model_regs[s][AW-1:0]; end
            4'd8: e_ea = pc + f;
            4'd9: e_ea = xr + f;
            4'd10: e_ea = bar + f;
            default: begin e_lat = 1; e_rd = 0; end
        endcase
        if (e_rd != 0) e_op = mem_word(e_ea);
        @(negedge clk);
        mode = m; field = f; reg_sel = s; start = 1'b1;
        rd0 = rd_cnt; cyc = 0; got = 0;
        while (!got && cyc < 30) begin
            @(negedge clk);
            cyc++;
            if (cyc == 1) begin
                start = 1'b0;
                if (disturb) begin
                    start = 1'b1; mode = 4'd1; field = ~f;
                    rf_we = 1'b1; rf_waddr = s; rf_wdata = 16'hDEAD;
                end
            end else if (cyc == 2) begin
                start = 1'b0; rf_we = 1'b0;
            end
            if (done) got = 1;
        end
        chk(got && cyc == e_lat, q, "latency", cyc, e_lat);
        chk(ea == e_ea, q, "ea", ea, e_ea);
        chk(operand == e_op, q, "operand", operand, e_op);
        chk(rd_cnt - rd0 == e_rd, q, "read count", rd_cnt - rd0, e_rd);
        chk(mode_err == (m > 4'd10), "R11", "mode_err", mode_err, (m > 4'd10));
    endtask

    task automatic check_reg(input logic [SW-1:0] s, input string q);
        logic [DW-1:0] e;
        e = model_regs[s];
        run_op(4'd4, '0, s, 1'b0);
        chk(operand == e, q, "register readback", operand, e);
    endtask

    task automatic run_all();
        repeat (3) @(negedge clk);
        // R1: reset state.
        chk(!done && !busy && !mem_re && !mode_err, "R1", "flags", {busy, done, mem_re, mode_err}, 0);
        chk(ea == '0 && operand == '0, "R1", "ea/operand", {ea, operand}, 0);
        rst_n = 1'b1;
        check_reg(3'd5, "R1");
        // Directed: every mode once.
        pc = 12'd202; xr = 12'd100; bar = 12'hFF0;
        write_reg(3'd1, 16'd400);
        run_op(4'd0, 12'd500, 3'd1, 1'b0);
        run_op(4'd1, 12'd500, 3'd1, 1'b0);
        run_op(4'd2, 12'd500, 3'd1, 1'b0);
        run_op(4'd3, 12'd500, 3'd1, 1'b0);
        run_op(4'd4, 12'd500, 3'd1, 1'b0);
        run_op(4'd5, 12'd500, 3'd1, 1'b0);
        check_reg(3'd1, "R7");
        run_op(4'd8, 12'd500, 3'd1, 1'b0);
        run_op(4'd9, 12'd500, 3'd1, 1'b0);
        run_op(4'd10, 12'd500, 3'd1, 1'b0);   // R10 wraps past 0xFFF
        // R8 / R9: repeated updates on one register, with wrap.
        write_reg(3'd2, 16'hFFFF);
        run_op(4'd6, '0, 3'd2, 1'b0);
        check_reg(3'd2, "R8");
        run_op(4'd7, '0, 3'd2, 1'b0);
        run_op(4'd7, '0, 3'd2, 1'b0);
        check_reg(3'd2, "R9");
        // R11: every undefined code.
        for (int c = 11; c < 16; c++) run_op(4'(c), 12'hABC, 3'd0, 1'b0);
        // R12: start and register write while busy.
        write_reg(3'd6, 16'h1234);
        run_op(4'd2, 12'h3C4, 3'd6, 1'b1);
        check_reg(3'd6, "R12");
        run_op(4'd3, 12'h7F0, 3'd6, 1'b1);
        check_reg(3'd6, "R12");
        // Random mix.
        for (int i = 0; i < 400; i++) begin
            if ($urandom_range(0, 4) == 0)
                write_reg(3'($urandom_range(0, NR - 1)), 16'($urandom));
            pc = 12'($urandom); xr = 12'($urandom); bar = 12'($urandom);
            run_op(4'($urandom_range(0, 15)), 12'($urandom),
                   3'($urandom_range(0, NR - 1)), 1'b0);
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < NR; i++) model_regs[i] = '0;
        fork
            run_all();
            begin
                repeat (150000) @(posedge clk);
                chk(1'b0, "R13", "watchdog expired", 0, 1);
            end
        join_any
        disable fork;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule